// File: doc/BRIEF.md
# Sliding-Scale Channel Width Corrector

This block is the digital half of a sliding-scale linearisation scheme for a pulse-height converter. An 8-bit binary counter supplies an offset code. The code is driven to a DAC port so that analog circuitry outside the block can add it to the held pulse before conversion. When the raw 13-bit conversion result comes back, the block subtracts that same offset and produces a corrected channel number. Because a different offset is applied to each conversion, the uneven channel widths of the converter are spread over neighbouring channels.

The offset is captured into a holding register when a conversion starts, and that held copy is the value subtracted. The counter steps only when a conversion completes, so the DAC code stays fixed while a conversion runs. A result smaller than its offset is reported as out of range and produces no valid channel.

Top module: `slide_corrector`

## Requirements
- R1: While reset is asserted and just after it is released, `dac_code` is 0 and `chan_valid` and `chan_oor` are 0.
- R2: `dac_code` always shows the offset counter, and it does not change in any cycle in which `raw_valid` is low.
- R3: Each cycle with `raw_valid` high increments the counter by one after that clock edge, and 255 is followed by 0.
- R4: A `conv_start` pulse captures the offset that `dac_code` shows after that edge. When `raw_valid` is high in the same cycle, this is the value after the step.
- R5: For a result with `raw_code` greater than or equal to the held offset, `chan_out` equals `raw_code` minus the held offset, and `chan_valid` is high, in the cycle after `raw_valid`.
- R6: For a result with `raw_code` smaller than the held offset, `chan_oor` is high and `chan_valid` is low for one cycle, and `chan_out` keeps its previous value.
- R7: `chan_valid` and `chan_oor` are high only in the cycle after a `raw_valid` cycle, and they are never high together.
- R8: The held offset stays unchanged until the next `conv_start`. Two results without a new start both subtract the same value, even though the counter has stepped between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion-start strobe that captures the offset |
| raw_valid | input | 1 | Strobe marking a raw conversion result |
| raw_code | input | 13 | Raw conversion result |
| dac_code | output | 8 | Offset code for the external DAC |
| chan_out | output | 13 | Corrected channel number |
| chan_valid | output | 1 | Corrected channel is valid |
| chan_oor | output | 1 | Result was below its offset (out of range) |

## Verification
A plain start followed by a result shows that the subtraction uses the held offset. A result taken exactly at the offset gives channel 0, and a result one below it gives the out-of-range outcome; together they locate the underflow boundary. A start in the same cycle as a result shows whether the stepped value or the old value is captured. Two results after one start show that the held copy, rather than the live counter, is subtracted. A run of more than 256 conversions with full-scale results exercises counter wrap and the top of the raw range.

// File: rtl/slide_pkg.sv
package slide_pkg;
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_OK   = 2'd1,
    RES_LOW  = 2'd2
  } res_kind_e;
endpackage

// File: rtl/offset_counter.sv
module offset_counter #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             capture,
  output logic [OFS_W-1:0] cnt_q,
  output logic [OFS_W-1:0] held_q
);
  logic [OFS_W-1:0] cnt_d;
  logic [OFS_W-1:0] held_d;

  // step after a completed conversion; a start in the same cycle takes the stepped code
  always_comb begin
    cnt_d  = cnt_q;
    held_d = held_q;
    if (step)    cnt_d  = cnt_q + {{(OFS_W-1){1'b0}}, 1'b1};
    if (capture) held_d = cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '0;
    end else begin
      if (step)    cnt_q  <= cnt_d;
      if (capture) held_q <= held_d;
    end
  end
endmodule

// File: rtl/channel_subtract.sv
module channel_subtract
  import slide_pkg::*;
#(
  parameter int RAW_W = 13,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_valid,
  input  logic [RAW_W-1:0] raw_code,
  input  logic [OFS_W-1:0] offset,
  output logic [RAW_W-1:0] chan_q,
  output logic             valid_q,
  output logic             oor_q
);
  localparam int PAD_W = RAW_W - OFS_W;

  logic [RAW_W:0]   diff;
  logic [RAW_W-1:0] chan_d;
  res_kind_e        kind;

  always_comb begin
    diff   = {1'b0, raw_code} - {1'b0, {PAD_W{1'b0}}, offset};
    chan_d = diff[RAW_W-1:0];
    if (!raw_valid)      kind = RES_NONE;
    else if (diff[RAW_W]) kind = RES_LOW;
    else                 kind = RES_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      oor_q   <= 1'b0;
    end else begin
      valid_q <= (kind == RES_OK);
      oor_q   <= (kind == RES_LOW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              chan_q <= '0;
    else if (kind == RES_OK) chan_q <= chan_d;
  end
endmodule

// File: rtl/slide_corrector.sv
module slide_corrector #(
  parameter int RAW_W = 13,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             raw_valid,
  input  logic [RAW_W-1:0] raw_code,
  output logic [OFS_W-1:0] dac_code,
  output logic [RAW_W-1:0] chan_out,
  output logic             chan_valid,
  output logic             chan_oor
);
  logic [OFS_W-1:0] held_ofs;

  offset_counter #(.OFS_W(OFS_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (raw_valid),
    .capture(conv_start),
    .cnt_q  (dac_code),
    .held_q (held_ofs)
  );

  channel_subtract #(.RAW_W(RAW_W), .OFS_W(OFS_W)) u_sub (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_valid(raw_valid),
    .raw_code (raw_code),
    .offset   (held_ofs),
    .chan_q   (chan_out),
    .valid_q  (chan_valid),
    .oor_q    (chan_oor)
  );
endmodule

// File: rtl/slide_corrector_checker.sv
module slide_corrector_checker #(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             raw_valid,
  input logic [OFS_W-1:0] dac_code,
  input logic             chan_valid,
  input logic             chan_oor
);
  a_r2_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |=> $stable(dac_code));

  a_r3_dac_step: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid |=> dac_code == ($past(dac_code) + {{(OFS_W-1){1'b0}}, 1'b1}));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(chan_valid && chan_oor));

  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |=> !chan_valid && !chan_oor);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> dac_code == '0 && !chan_valid && !chan_oor);
endmodule

bind slide_corrector slide_corrector_checker #(.OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .raw_valid (raw_valid),
  .dac_code  (dac_code),
  .chan_valid(chan_valid),
  .chan_oor  (chan_oor)
);

// File: tb/slide_corrector_bench.sv
`timescale 1ns/1ps
module slide_corrector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic        raw_valid = 1'b0;
  logic [12:0] raw_code = '0;
  logic [7:0]  dac_code;
  logic [12:0] chan_out;
  logic        chan_valid;
  logic        chan_oor;

  int n_cmp = 0;
  int n_bad = 0;

  // model state kept from the requirements
  logic [7:0]  m_cnt = '0;
  logic [7:0]  m_held = '0;
  logic [12:0] m_out = '0;

  always #2.5 clk = ~clk;

  slide_corrector u_slide_corrector (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .raw_valid(raw_valid),
    .raw_code(raw_code), .dac_code(dac_code), .chan_out(chan_out),
    .chan_valid(chan_valid), .chan_oor(chan_oor)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with the given strobes, then checks against the model
  task automatic cyc(input string req, input logic st, input logic rv, input int raw);
    logic ev, eo;
    conv_start = st;
    raw_valid  = rv;
    raw_code   = 13'(raw);
    ev = 1'b0;
    eo = 1'b0;
    if (rv) begin
      if (raw >= int'(m_held)) begin ev = 1'b1; m_out = 13'(raw - int'(m_held)); end
      else eo = 1'b1;
      m_cnt = m_cnt + 8'd1;
    end
    if (st) m_held = m_cnt;
    @(negedge clk);
    conv_start = 1'b0;
    raw_valid  = 1'b0;
    chk({req, " dac"}, int'(dac_code), int'(m_cnt));
    chk({req, " valid"}, int'(chan_valid), int'(ev));
    chk({req, " oor"}, int'(chan_oor), int'(eo));
    chk({req, " chan"}, int'(chan_out), int'(m_out));
  endtask

  task automatic t_reset;
    chk("R1 dac in reset", int'(dac_code), 0);
    chk("R1 valid in reset", int'(chan_valid), 0);
    chk("R1 oor in reset", int'(chan_oor), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dac after release", int'(dac_code), 0);
    chk("R1 valid after release", int'(chan_valid), 0);
  endtask

  task automatic t_basic;
    cyc("R4 start", 1'b1, 1'b0, 0);
    cyc("R2 idle", 1'b0, 1'b0, 0);
    cyc("R5 result", 1'b0, 1'b1, 100);   // held 0 -> 100
    cyc("R4 start", 1'b1, 1'b0, 0);      // held 1
    cyc("R5 result", 1'b0, 1'b1, 500);   // 499
    chk("R5 value 499", int'(chan_out), 499);
    cyc("R7 idle", 1'b0, 1'b0, 0);
  endtask

  task automatic t_underflow;
    cyc("R4 start", 1'b1, 1'b0, 0);      // held 2
    cyc("R6 below", 1'b0, 1'b1, 1);
    chk("R6 chan kept", int'(chan_out), 499);
    cyc("R4 start", 1'b1, 1'b0, 0);      // held 3
    cyc("R5 zero", 1'b0, 1'b1, 3);
    chk("R5 boundary zero", int'(chan_out), 0);
  endtask

  task automatic t_same_cycle;
    cyc("R4 start", 1'b1, 1'b0, 0);      // held 4
    cyc("R4 both", 1'b1, 1'b1, 40);      // 36, held becomes 5
    cyc("R4 after both", 1'b0, 1'b1, 40);
    chk("R4 stepped capture", int'(chan_out), 35);
  endtask

  task automatic t_stale;
    cyc("R4 start", 1'b1, 1'b0, 0);      // held 6
    cyc("R8 first", 1'b0, 1'b1, 1000);
    cyc("R8 second", 1'b0, 1'b1, 1000);
    chk("R8 same offset", int'(chan_out), 994);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 260; i++) begin
      cyc("R3 wrap start", 1'b1, 1'b0, 0);
      cyc("R3 wrap result", 1'b0, 1'b1, 8191);
    end
  endtask

  initial begin
    fork
      begin
        #2;
        t_reset();
        t_basic();
        t_underflow();
        t_same_cycle();
        t_stale();
        t_wrap();
      end
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule